// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block holds one pending flag per peripheral source and picks, once per instruction, the single request that should be serviced next. Every source carries its own enable and a programmable priority with two fields: a 4-bit interrupt level and a 2-bit group sub-level. The group sub-level only breaks ties between sources of equal level. The same selection serves ordinary CPU interrupts and peripheral transfer-service requests. Each instruction yields at most one winner.

The decision is taken only on a clock edge where the end-of-instruction strobe is high. The best candidate is granted only when its level is strictly above the live CPU priority level. A grant is a one-cycle pulse that reports the granted level, the source's trap number and its vector address, which is four times the trap number. On the same edge, the winner's pending flag is cleared. A request pulse that lands on that same edge keeps the flag set.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, `grant_vld` is 0, and `req_pend`, `grant_lvl`, `grant_trap` and `grant_vec` are all zero.
- R2: A 1 on `req_set[i]` at a clock edge sets `req_pend[i]` from the next cycle. The flag stays set until it is granted.
- R3: Only sources with both `req_pend[i]` and `req_en[i]` set compete. A pending source that is disabled is never granted and keeps its flag.
- R4: A decision is made only on an edge where `eoi` is 1. `grant_vld` is 1 for exactly the cycle after such an edge, and only when a grant is issued.
- R5: Among competitors, the higher level wins whatever the group values. The level of source i is `src_lvl[4i+3:4i]`.
- R6: Among competitors of equal level, the higher group value wins. The group of source i is `src_grp[2i+1:2i]`.
- R7: When level and group are both identical, the lower source index wins.
- R8: A grant is issued only if the winner's level is strictly greater than `cpu_lvl`. A level of 0 is never granted.
- R9: `grant_trap` equals TRAP_BASE (default 0x20) plus the winning index. `grant_vec` equals `grant_trap` multiplied by 4.
- R10: `grant_lvl` equals the level the winner had at the decision edge.
- R11: At the grant edge, the winner's pending flag is cleared. All other pending flags are left unchanged.
- R12: If `req_set` for the winner is 1 on its grant edge, its pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoi | input | 1 | End-of-instruction strobe; a decision is taken on edges where it is high |
| cpu_lvl | input | LVL_W | Current CPU priority level |
| req_set | input | NSRC | Per-source request pulses |
| req_en | input | NSRC | Per-source enables |
| src_lvl | input | NSRC*LVL_W | Per-source interrupt level, source i at bits [LVL_W*i +: LVL_W] |
| src_grp | input | NSRC*GRP_W | Per-source group sub-level, source i at bits [GRP_W*i +: GRP_W] |
| grant_vld | output | 1 | One-cycle grant pulse |
| grant_lvl | output | LVL_W | Level of the granted source; zero when there is no grant |
| grant_trap | output | TRAP_W | Trap number of the granted source; zero when there is no grant |
| grant_vec | output | TRAP_W+2 | Vector address (trap times 4); zero when there is no grant |
| req_pend | output | NSRC | Current pending flags |

## Verification
Two actions can hit the same flag on one edge: the clear caused by a grant and a new request pulse from the peripheral. The bench provokes this directly. It pulses `req_set` of the source that is about to win on the very edge where `eoi` is high. It then requires both a grant for that source and a pending flag that is still set afterwards. A second strobe then drains the flag. Random traffic mixes request pulses, strobes and priority changes, so this collision and a grant to one source while another source is set also occur many times. Each of these cycles is judged against a behavioural model that applies the clear first and the set second.

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NSRC      = 8,
  parameter int LVL_W     = 4,
  parameter int GRP_W     = 2,
  parameter int TRAP_W    = 8,
  parameter int TRAP_BASE = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    eoi,
  input  logic [LVL_W-1:0]        cpu_lvl,
  input  logic [NSRC-1:0]         req_set,
  input  logic [NSRC-1:0]         req_en,
  input  logic [NSRC*LVL_W-1:0]   src_lvl,
  input  logic [NSRC*GRP_W-1:0]   src_grp,
  output logic                    grant_vld,
  output logic [LVL_W-1:0]        grant_lvl,
  output logic [TRAP_W-1:0]       grant_trap,
  output logic [TRAP_W+1:0]       grant_vec,
  output logic [NSRC-1:0]         req_pend
);
  localparam int KEY_W = LVL_W + GRP_W;
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  cand;
  logic [KEY_W-1:0] best_key;
  logic [IDX_W-1:0] best_idx;
  logic             best_any;
  logic [LVL_W-1:0] win_lvl;
  logic             take;
  logic [NSRC-1:0]  clr;
  logic [TRAP_W-1:0] win_trap;

  assign cand = req_pend & req_en;

  always_comb begin
    best_key = '0;
    best_idx = '0;
    best_any = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!best_any ||
          {src_lvl[i*LVL_W +: LVL_W], src_grp[i*GRP_W +: GRP_W]} > best_key)) begin
        best_key = {src_lvl[i*LVL_W +: LVL_W], src_grp[i*GRP_W +: GRP_W]};
        best_idx = IDX_W'(i);
        best_any = 1'b1;
      end
    end
  end

  assign win_lvl  = best_key[KEY_W-1 -: LVL_W];
  assign take     = eoi && best_any && (win_lvl > cpu_lvl);
  assign clr      = take ? (NSRC'(1) << best_idx) : '0;
  assign win_trap = TRAP_W'(TRAP_BASE) + TRAP_W'(best_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_pend   <= '0;
      grant_vld  <= 1'b0;
      grant_lvl  <= '0;
      grant_trap <= '0;
      grant_vec  <= '0;
    end else begin
      req_pend   <= (req_pend & ~clr) | req_set;
      grant_vld  <= take;
      grant_lvl  <= take ? win_lvl : '0;
      grant_trap <= take ? win_trap : '0;
      grant_vec  <= take ? {win_trap, 2'b00} : '0;
    end
  end
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int NSRC      = 8,
  parameter int LVL_W     = 4,
  parameter int TRAP_W    = 8,
  parameter int TRAP_BASE = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eoi,
  input logic [LVL_W-1:0]  cpu_lvl,
  input logic [NSRC-1:0]   req_set,
  input logic              grant_vld,
  input logic [LVL_W-1:0]  grant_lvl,
  input logic [TRAP_W-1:0] grant_trap,
  input logic [NSRC-1:0]   req_pend
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  set_q;
  logic [IDX_W-1:0] widx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) set_q <= '0;
    else        set_q <= req_set;

  assign widx = IDX_W'(grant_trap - TRAP_W'(TRAP_BASE));

  p_grant_on_eoi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> $past(eoi));

  p_grant_above_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> (grant_lvl > $past(cpu_lvl)));

  p_trap_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> (int'(grant_trap) >= TRAP_BASE && int'(grant_trap) < TRAP_BASE + NSRC));

  p_winner_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> (!req_pend[widx] || set_q[widx]));

  p_set_sticks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q != '0) |-> ((req_pend & set_q) == set_q));
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
  .NSRC(NSRC), .LVL_W(LVL_W), .TRAP_W(TRAP_W), .TRAP_BASE(TRAP_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .eoi(eoi), .cpu_lvl(cpu_lvl), .req_set(req_set),
  .grant_vld(grant_vld), .grant_lvl(grant_lvl), .grant_trap(grant_trap),
  .req_pend(req_pend)
);

// File: tb/tb_irq_prio_arbiter.sv
`timescale 1ns/1ps
module tb_irq_prio_arbiter;
  localparam int N = 8;
  localparam int BASE = 32;

  logic clk = 0, rst_n = 0, eoi = 0;
  logic [3:0]   cpu_lvl = 0;
  logic [N-1:0] req_set = 0, req_en = 0;
  logic [4*N-1:0] src_lvl = 0;
  logic [2*N-1:0] src_grp = 0;
  logic grant_vld;
  logic [3:0] grant_lvl;
  logic [7:0] grant_trap;
  logic [9:0] grant_vec;
  logic [N-1:0] req_pend;

  int checks = 0, fails = 0;

  irq_prio_arbiter dut (
    .clk(clk), .rst_n(rst_n), .eoi(eoi), .cpu_lvl(cpu_lvl), .req_set(req_set),
    .req_en(req_en), .src_lvl(src_lvl), .src_grp(src_grp), .grant_vld(grant_vld),
    .grant_lvl(grant_lvl), .grant_trap(grant_trap), .grant_vec(grant_vec),
    .req_pend(req_pend)
  );

  always #10 clk = ~clk;

  // behavioural reference
  bit m_pend[N];
  int m_vld, m_lvl, m_trap, m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_pend[i]) m_pend[i] = 0;
      m_vld = 0; m_lvl = 0; m_trap = 0; m_vec = 0;
    end else begin
      int best, bk;
      best = -1; bk = -1;
      for (int i = 0; i < N; i++)
        if (m_pend[i] && req_en[i]) begin
          int k;
          k = int'(src_lvl[i*4 +: 4]) * 4 + int'(src_grp[i*2 +: 2]);
          if (k > bk) begin bk = k; best = i; end
        end
      if (eoi && best >= 0 && (bk / 4) > int'(cpu_lvl)) begin
        m_vld = 1; m_lvl = bk / 4; m_trap = BASE + best; m_vec = (BASE + best) * 4;
        m_pend[best] = 0;
      end else begin
        m_vld = 0; m_lvl = 0; m_trap = 0; m_vec = 0;
      end
      for (int i = 0; i < N; i++) if (req_set[i]) m_pend[i] = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int mp;
    mp = 0;
    for (int i = 0; i < N; i++) if (m_pend[i]) mp |= (1 << i);
    chk(int'(grant_vld) == m_vld, "model R4/R8 grant_vld", grant_vld, m_vld);
    chk(int'(grant_lvl) == m_lvl, "model R10 grant_lvl", grant_lvl, m_lvl);
    chk(int'(grant_trap) == m_trap, "model R9 grant_trap", grant_trap, m_trap);
    chk(int'(grant_vec) == m_vec, "model R9 grant_vec", grant_vec, m_vec);
    chk(int'(req_pend) == mp, "model R11 req_pend", req_pend, mp);
  end

  task automatic cfg(input int i, input int l, input int g);
    src_lvl[i*4 +: 4] = 4'(l);
    src_grp[i*2 +: 2] = 2'(g);
  endtask

  task automatic step(input bit e, input logic [N-1:0] s);
    eoi = e; req_set = s;
    @(negedge clk);
    eoi = 0; req_set = 0;
  endtask

  task automatic expect_grant(input string tag, input int trap, input int lvl);
    chk(grant_vld == 1, tag, grant_vld, 1);
    chk(int'(grant_trap) == trap, tag, grant_trap, trap);
    chk(int'(grant_vec) == trap * 4, tag, grant_vec, trap * 4);
    chk(int'(grant_lvl) == lvl, tag, grant_lvl, lvl);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    report;
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(grant_vld == 0, "R1 grant_vld", grant_vld, 0);
    chk(req_pend == 0, "R1 req_pend", req_pend, 0);
    chk(grant_vec == 0 && grant_trap == 0, "R1 vec/trap", grant_vec, 0);
    // R2 / R3: pending but disabled
    cfg(3, 5, 0);
    step(0, 8'h08);
    chk(req_pend[3] == 1, "R2 set", req_pend[3], 1);
    step(1, 0);
    chk(grant_vld == 0, "R3 disabled no grant", grant_vld, 0);
    chk(req_pend[3] == 1, "R3 disabled keeps flag", req_pend[3], 1);
    // R4
    req_en = 8'h08;
    step(0, 0); step(0, 0);
    chk(grant_vld == 0, "R4 no strobe", grant_vld, 0);
    step(1, 0);
    expect_grant("R4 R9 R10 grant src3", 8'h23, 5);
    chk(req_pend[3] == 0, "R11 cleared", req_pend[3], 0);
    step(0, 0);
    chk(grant_vld == 0, "R4 single pulse", grant_vld, 0);
    // R5
    cfg(1, 7, 0); cfg(2, 6, 3); req_en = 8'h06;
    step(0, 8'h06);
    step(1, 0);
    expect_grant("R5 higher level", 8'h21, 7);
    chk(req_pend[2] == 1, "R11 others kept", req_pend[2], 1);
    step(1, 0);
    expect_grant("R5 next", 8'h22, 6);
    // R6
    cfg(4, 9, 1); cfg(5, 9, 2); req_en = 8'h30;
    step(0, 8'h30);
    step(1, 0);
    expect_grant("R6 higher group", 8'h25, 9);
    step(1, 0);
    expect_grant("R6 next", 8'h24, 9);
    // R7
    cfg(6, 3, 2); cfg(7, 3, 2); req_en = 8'hC0;
    step(0, 8'hC0);
    step(1, 0);
    expect_grant("R7 lower index", 8'h26, 3);
    step(1, 0);
    expect_grant("R7 next", 8'h27, 3);
    // R8
    cfg(0, 9, 0); req_en = 8'h01; cpu_lvl = 9;
    step(0, 8'h01);
    step(1, 0);
    chk(grant_vld == 0, "R8 equal level blocked", grant_vld, 0);
    chk(req_pend[0] == 1, "R8 flag kept", req_pend[0], 1);
    cpu_lvl = 8;
    step(1, 0);
    expect_grant("R8 above cpu", 8'h20, 9);
    cpu_lvl = 0; cfg(2, 0, 3); req_en = 8'h04;
    step(0, 8'h04);
    step(1, 0);
    chk(grant_vld == 0, "R8 level zero", grant_vld, 0);
    chk(req_pend[2] == 1, "R8 level zero pending", req_pend[2], 1);
    // R12
    req_en = 8'h02; cfg(1, 7, 0);
    step(0, 8'h02);
    step(1, 8'h02);
    expect_grant("R12 grant with set", 8'h21, 7);
    chk(req_pend[1] == 1, "R12 set wins", req_pend[1], 1);
    step(1, 0);
    expect_grant("R12 drain", 8'h21, 7);
    chk(req_pend[1] == 0, "R12 drained", req_pend[1], 0);
    // random traffic, compared against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      if (c % 50 == 0) begin
        for (int i = 0; i < N; i++) cfg(i, $urandom % 16, $urandom % 4);
        req_en = N'($urandom);
      end
      cpu_lvl = 4'($urandom % 8);
      step(($urandom % 3) == 0, N'($urandom) & N'($urandom) & N'($urandom));
    end
    report;
    $finish;
  end
endmodule